// File: doc/BRIEF.md
# Serial Start Condition Detector

This block watches the clock and data lines of a two-line serial bus and keeps a sticky event flag, with an interrupt request gated by an enable bit. In two-wire operation the flag marks a bus start condition, which is a falling data line while the clock line is high. In the other two operating modes, three-wire and output-disabled, the flag can instead catch every edge of the clock pin, so the detector also works as a plain edge-triggered external interrupt. The clock-source field and the strobe-select bit choose when that happens.

Both bus lines are oversampled on the block clock through two-flop synchronizers. The data line then goes through a short delay line of `DATA_DLY` sample periods, and the clock line does not. A start is qualified by the clock level seen at the moment of the delayed data transition. This filters out the normal case where the data line changes just after the clock line falls. Software clears the flag by pulsing the clear input. The flag is held by a simple level, and the request output is combinational from it, so the event stays visible for wake-up logic in another clock domain.

Top module: `ssd_top`

## Requirements
- R1: During and right after reset, `flag_o` and `irq_o` are 0. The synchronized bus state resets to idle (both lines high), so releasing reset with the lines high raises no event.
- R2: With `mode_i` at 2'b10 or 2'b11 (two-wire), a fall of `sda_i` while `scl_i` stays high sets `flag_o` on the (3+`DATA_DLY`)-th rising clock edge after the input change, and no earlier.
- R3: In two-wire mode, a data fall while the clock line is low does not set the flag, and neither does a data rise while the clock line is high.
- R4: A start is qualified by the clock level at the delayed data transition. If `scl_i` falls `DATA_DLY` or fewer cycles after `sda_i` falls, no event is raised. If it falls `DATA_DLY`+1 cycles after, the start is recorded.
- R5: With `mode_i` at 2'b00 (output-disabled) or 2'b01 (three-wire), `clk_src_i` at 2'b10 or 2'b11 and `strobe_sel_i` at 0, both rising and falling edges of `scl_i` set `flag_o` on the third rising clock edge after the input change.
- R6: Clock-pin edges do not set the flag in two-wire mode, when `clk_src_i[1]` is 0, or when `strobe_sel_i` is 1.
- R7: Start detection is off outside two-wire mode. A data fall with the clock line high then leaves the flag at 0.
- R8: Once set, `flag_o` stays at 1 until a cycle with `flag_clr_i` at 1. After that cycle it reads 0 if no event occurred in the same cycle.
- R9: An event in the same cycle as a clear leaves `flag_o` at 1.
- R10: `irq_o` is 1 exactly when `flag_o` and `ie_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 output-disabled, 01 three-wire, 10/11 two-wire |
| clk_src_i | input | 2 | Clock-source select; bit 1 enables clock-pin edge events |
| strobe_sel_i | input | 1 | Strobe select; 1 blocks clock-pin edge events |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line |
| ie_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one clear of the flag |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A clock-pin edge reaches `flag_o` three rising edges after the input change: two synchronizer stages, then the flag register. A start condition takes `DATA_DLY` more edges because of the data delay line. A clear, and a clear that collides with an event, take effect on the next edge. The directed checks drive inputs at the falling edge and sample at a falling edge after exactly that many rising edges, and they also check that the flag is still clear one edge earlier. The random phase compares every cycle against a bench model. The model keeps a history of applied inputs and picks, for each flag update, the entries whose age matches the pipeline depth.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    typedef enum logic [1:0] {
        BM_OFF  = 2'b00,
        BM_3W   = 2'b01,
        BM_2W   = 2'b10,
        BM_2WH  = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef struct packed {
        logic start;
        logic clk_edge;
    } evt_t;

    function automatic logic is_two_wire(bus_mode_e m);
        return m[1];
    endfunction

    function automatic logic edge_sel(bus_mode_e m, logic [1:0] cs, logic strobe);
        return !m[1] && cs[1] && !strobe;
    endfunction

endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[i] <= '1;
            else if (i == 0)
                stg[i] <= d_i;
            else
                stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ssd_delay.sv
module ssd_delay #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    if (DLY == 0) begin : g_pass
        assign q_o = d_i;
    end else begin : g_line
        logic [DLY-1:0] line;
        always_ff @(posedge clk) begin
            if (rst)
                line <= '1;
            else if (DLY == 1)
                line <= d_i;
            else
                line <= {line[(DLY > 1 ? DLY-2 : 0):0], d_i};
        end
        assign q_o = line[DLY-1];
    end
endmodule

// File: rtl/ssd_evt.sv
module ssd_evt
    import ssd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_mode_e  mode,
    input  logic [1:0] cs,
    input  logic       strobe,
    input  logic       scl_s,
    input  logic       sda_d,
    output evt_t       evt_o
);
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_d;
        end
    end

    always_comb begin
        evt_o.start    = is_two_wire(mode) && sda_prev && !sda_d && scl_s;
        evt_o.clk_edge = edge_sel(mode, cs, strobe) && (scl_s != scl_prev);
    end
endmodule

// File: rtl/ssd_top.sv
module ssd_top
    import ssd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_DLY    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic [1:0] clk_src_i,
    input  logic       strobe_sel_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       ie_i,
    input  logic       flag_clr_i,
    output logic       flag_o,
    output logic       irq_o
);
    localparam int BUS_W = $bits(bus_t);

    bus_t      bus_raw;
    bus_t      bus_s;
    logic      sda_dly;
    evt_t      evt;
    logic      flag_q;
    bus_mode_e mode;

    assign mode        = bus_mode_e'(mode_i);
    assign bus_raw.scl = scl_i;
    assign bus_raw.sda = sda_i;

    ssd_sync #(.STAGES(SYNC_STAGES), .W(BUS_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (bus_raw),
        .q_o (bus_s)
    );

    ssd_delay #(.DLY(DATA_DLY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d_i (bus_s.sda),
        .q_o (sda_dly)
    );

    ssd_evt u_evt (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .cs     (clk_src_i),
        .strobe (strobe_sel_i),
        .scl_s  (bus_s.scl),
        .sda_d  (sda_dly),
        .evt_o  (evt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (evt.start || evt.clk_edge)
            flag_q <= 1'b1;
        else if (flag_clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/ssd_chk.sv
module ssd_chk
    import ssd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_i,
    input logic       flag_clr_i,
    input logic       ie_i,
    input logic       flag_o,
    input logic       irq_o,
    input evt_t       evt
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !flag_o);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flag_o && !flag_clr_i |=> flag_o);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flag_clr_i && !evt.start && !evt.clk_edge |=> !flag_o);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start || evt.clk_edge |=> flag_o);

    // R7
    no_start_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_i[1] |-> !evt.start);

    // R6
    no_edge_2w_chk: assert property (@(posedge clk) disable iff (rst)
        mode_i[1] |-> !evt.clk_edge);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ie_i |-> !irq_o);

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);
endmodule

bind ssd_top ssd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .flag_clr_i (flag_clr_i),
    .ie_i       (ie_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .evt        (evt)
);

// File: tb/sim_ssd_top.sv
module sim_ssd_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int D = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b10;
    logic [1:0] cs = 2'b00;
    logic       strobe = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       ie = 1'b0;
    logic       clr = 1'b0;
    logic       flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ssd_top #(.SYNC_STAGES(2), .DATA_DLY(D)) u0 (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode),
        .clk_src_i    (cs),
        .strobe_sel_i (strobe),
        .scl_i        (scl),
        .sda_i        (sda),
        .ie_i         (ie),
        .flag_clr_i   (clr),
        .flag_o       (flag),
        .irq_o        (irq)
    );

    // bench model built from input history; index 0 is the value present at this edge
    logic [7:0] sh, dh;
    logic       fm;
    always @(posedge clk) begin
        if (rst) begin
            sh = '1; dh = '1; fm = 1'b0;
        end else begin
            sh = {sh[6:0], scl};
            dh = {dh[6:0], sda};
            if (exp_event(mode, cs, strobe, sh[2], sh[3], dh[2+D], dh[3+D]))
                fm = 1'b1;
            else if (clr)
                fm = 1'b0;
        end
    end

    function automatic logic exp_event(logic [1:0] m, logic [1:0] c, logic s,
                                       logic scl_now, logic scl_old,
                                       logic sda_now, logic sda_old);
        logic st, ed;
        st = m[1] && sda_old && !sda_now && scl_now;
        ed = !m[1] && c[1] && !s && (scl_now != scl_old);
        return st || ed;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        clr = 1'b1; tick(1); clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        // R1
        check(flag, 1'b0, "R1 flag in reset");
        check(irq, 1'b0, "R1 irq in reset");
        rst = 1'b0;
        tick(6);
        check(flag, 1'b0, "R1 flag after reset release");

        // R2 start condition, exact timing
        mode = 2'b10; ie = 1'b1;
        sda = 1'b0;
        tick(2 + D);
        check(flag, 1'b0, "R2 not before 3+DLY edges");
        tick(1);
        check(flag, 1'b1, "R2 start sets flag");
        check(irq, 1'b1, "R10 irq with enable");
        // R8 sticky
        tick(10);
        check(flag, 1'b1, "R8 flag stays set");
        clear_flag();
        check(flag, 1'b0, "R8 clear");
        // R3 data rise with clock high
        sda = 1'b1; tick(8);
        check(flag, 1'b0, "R3 data rise ignored");

        // R3 data fall with clock low; R6 clock rise in two-wire
        scl = 1'b0; tick(6);
        sda = 1'b0; tick(8);
        check(flag, 1'b0, "R3 fall with clock low");
        sda = 1'b1; tick(3);
        scl = 1'b1; tick(8);
        check(flag, 1'b0, "R6 no clock edge in two-wire");

        // R4 clock falls too soon after data
        mode = 2'b11;
        sda = 1'b0; tick(D);
        scl = 1'b0; tick(10);
        check(flag, 1'b0, "R4 short hold rejected");
        scl = 1'b1; tick(4); sda = 1'b1; tick(8);
        check(flag, 1'b0, "R3 stop ignored");
        // R4 hold of DLY+1 cycles accepted
        sda = 1'b0; tick(D + 1);
        scl = 1'b0; tick(10);
        check(flag, 1'b1, "R4 hold DLY+1 accepted");
        scl = 1'b1; tick(4); sda = 1'b1; tick(8);
        clear_flag();
        check(flag, 1'b0, "R8 clear after R4");

        // R5 clock-pin edges in three-wire mode
        mode = 2'b01; cs = 2'b11; strobe = 1'b0;
        tick(4);
        scl = 1'b0; tick(2);
        check(flag, 1'b0, "R5 not before 3 edges");
        tick(1);
        check(flag, 1'b1, "R5 falling edge sets");
        clear_flag();
        scl = 1'b1; tick(3);
        check(flag, 1'b1, "R5 rising edge sets");
        clear_flag();
        mode = 2'b00; cs = 2'b10;
        scl = 1'b0; tick(3);
        check(flag, 1'b1, "R5 output-disabled cs=10");
        clear_flag();
        scl = 1'b1; tick(4); clear_flag();

        // R7 no start outside two-wire
        cs = 2'b00;
        sda = 1'b0; tick(10);
        check(flag, 1'b0, "R7 start ignored in output-disabled");
        sda = 1'b1; tick(6);

        // R6 blocked encodings
        cs = 2'b01;
        scl = 1'b0; tick(3); scl = 1'b1; tick(6);
        check(flag, 1'b0, "R6 cs=01 blocks");
        cs = 2'b11; strobe = 1'b1;
        scl = 1'b0; tick(3); scl = 1'b1; tick(6);
        check(flag, 1'b0, "R6 strobe=1 blocks");
        strobe = 1'b0; mode = 2'b10;
        scl = 1'b0; tick(3); scl = 1'b1; tick(6);
        check(flag, 1'b0, "R6 two-wire blocks edges");

        // R9 set in the same cycle as clear
        mode = 2'b01; cs = 2'b11;
        scl = 1'b0; tick(2);
        clr = 1'b1; tick(1); clr = 1'b0;
        check(flag, 1'b1, "R9 set wins over clear");
        // R10 enable gating
        ie = 1'b0; #1;
        check(irq, 1'b0, "R10 irq masked");
        ie = 1'b1; #1;
        check(irq, 1'b1, "R10 irq unmasked");
        clear_flag();
        scl = 1'b1; tick(4); clear_flag();
        check(flag, fm, "R8 model aligned");

        // random phase against the history model
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) begin
                mode = 2'($urandom_range(0, 3));
                cs = 2'($urandom_range(0, 3));
                strobe = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 3) == 0) scl = ~scl;
            if ($urandom_range(0, 3) == 0) sda = ~sda;
            clr = ($urandom_range(0, 15) == 0);
            ie = 1'($urandom_range(0, 1));
            tick(1);
            check(flag, fm, mode[1] ? "R2 random two-wire" : "R5 random edge mode");
            check(irq, fm & ie, "R10 random irq");
        end
        finish_run();
    end
endmodule